// File: doc/BRIEF.md
# Configurable Audio Frame Serializer

This block is the transmit side of a multi-format audio serial port acting as bus master. It divides the system clock into a bit clock, generates a frame sync, and sends 32-bit words from a parallel valid/ready input one bit at a time on a single data line. Run-time fields shape the framing, so one engine covers I2S, left-justified, right-justified, DSP and TDM layouts. These fields are the sync width, early or aligned sync, the sync level, the slot size, the slot count, the bit order, the bit clock edge and a per-slot mask.

A frame is a run of slots, and each slot is a run of bit-clock periods. At the start of each slot that is not masked, the block takes one word from the input. In MSB-first mode the slot sends the word's top bits. This means a 24-bit or 16-bit sample is placed left-aligned in the word, and right-justified layouts are built by zero-filling the upper bits. Masked slots take no word and drive zeros. The fields must stay fixed while the enable is high. After the enable drops, the output pins go back to idle, and the next enable starts again from the first bit of a fresh frame.

Top module: `audio_frame_tx`

## Requirements
- R1: With divider field D (8 bits), the bit clock period is 2*(D+1) system clocks. Each level lasts D+1 clocks.
- R2: While `en` is low, the outputs sit at idle: `bclk_o` = NOT `bclk_inv_i`, `fsync_o` = `fs_low_i` (inactive), `sd_o` = 0 and `underrun_o` = 0. After `en` rises, the first bit driven is bit 0 of slot 0 of a new frame.
- R3: With `bclk_inv_i`=0, `sd_o` and `fsync_o` change only on falling edges of `bclk_o`, and a receiver samples them on rising edges. With `bclk_inv_i`=1 the two edges swap roles.
- R4: A frame has (`slot_num_i`+1) slots of (`slot_bits_i`+1) bits. In aligned mode (`fs_early_i`=0) the sync is active for frame bit positions 0 through `fs_width_i`, counted from 0.
- R5: In early mode (`fs_early_i`=1) the sync window moves one bit earlier. It is active on the last bit of the frame and on positions 0 through `fs_width_i`-1.
- R6: The sync is active high when `fs_low_i`=0 and active low when `fs_low_i`=1.
- R7: With `lsb_first_i`=0, bit b of a slot (counted from 0) carries bit 31-b of the slot's word.
- R8: With `lsb_first_i`=1, bit b of a slot carries bit b of the word.
- R9: When bit s of `slot_mask_i` is 1, slot s takes no input word (`in_ready` stays low at its start) and drives 0 for the whole slot.
- R10: If an unmasked slot starts while `in_valid` is low, that slot sends zeros and `underrun_o` goes to 1. The flag stays set until `en` goes low.
- R11: Exactly one word is accepted at the start of each unmasked slot. `in_ready` is a one-clock pulse in the cycle before the slot's first bit appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low returns the outputs to idle |
| div_i | input | 8 | Bit clock divider; half period = div_i+1 clocks |
| bclk_inv_i | input | 1 | Swaps the drive and sample edges of the bit clock |
| fs_early_i | input | 1 | 1: sync asserts one bit before the frame |
| fs_low_i | input | 1 | 1: sync active low |
| fs_width_i | input | 5 | Sync width in bits minus one |
| slot_bits_i | input | 5 | Slot size in bits minus one |
| slot_num_i | input | 4 | Slots per frame minus one |
| lsb_first_i | input | 1 | 1: send word LSB first |
| slot_mask_i | input | 16 | 1 per slot: skip input, send zeros |
| in_valid | input | 1 | Input word available |
| in_ready | output | 1 | Word accepted this cycle |
| in_data | input | 32 | Input word |
| bclk_o | output | 1 | Bit clock |
| fsync_o | output | 1 | Frame sync |
| sd_o | output | 1 | Serial data |
| underrun_o | output | 1 | Sticky underrun flag |

## Verification
The assertions check, on every cycle, the properties that hold locally in time. These are: data and sync change only on the drive edge of the bit clock; the bit clock holds its level for more than one clock when the divider is non-zero; the pins are idle after a disabled cycle; the underrun flag stays set while enabled; and `in_ready` is raised only in a drive cycle. The framing itself can only be shown by the bench scenarios. The bench rebuilds the expected sync and data stream at every sample edge and compares it against the output. It covers the sync window position in each mode, bit order, masked slots, the word count consumed, underrun behaviour and the exact bit clock period across several divider values and formats.

// File: rtl/afs_pkg.sv
package afs_pkg;
    localparam int WORD_W    = 32;
    localparam int MAX_SLOTS = 16;
    localparam int DIV_W     = 8;
    localparam int BIT_W     = $clog2(WORD_W);
    localparam int SLOT_W    = $clog2(MAX_SLOTS);
    localparam int FPOS_W    = BIT_W + SLOT_W;

    // position of the bit being driven inside the frame
    typedef struct packed {
        logic [SLOT_W-1:0] slot;
        logic [BIT_W-1:0]  bitn;
        logic [FPOS_W-1:0] fcnt;
    } fpos_t;

    // frame geometry as seen by the sequencer
    typedef struct packed {
        logic              early;
        logic [BIT_W-1:0]  sync_m1;
        logic [BIT_W-1:0]  bits_m1;
        logic [SLOT_W-1:0] slots_m1;
    } geom_t;

    function automatic logic pick_bit(input logic [WORD_W-1:0] w,
                                      input logic [BIT_W-1:0]  idx,
                                      input logic              lsb);
        logic [BIT_W-1:0] ridx;
        ridx = BIT_W'(WORD_W - 1) - idx;
        return lsb ? w[idx] : w[ridx];
    endfunction

    function automatic logic is_last(input fpos_t p, input geom_t g);
        return (p.slot == g.slots_m1) && (p.bitn == g.bits_m1);
    endfunction
endpackage

// File: rtl/afs_bclk_div.sv
module afs_bclk_div
    import afs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             bclk_int,
    output logic             drive_evt
);
    logic [DIV_W-1:0] hcnt;
    logic             tick;

    assign tick      = en && (hcnt == div);
    assign drive_evt = tick && bclk_int;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            hcnt     <= '0;
            bclk_int <= 1'b1;
        end else if (tick) begin
            hcnt     <= '0;
            bclk_int <= ~bclk_int;
        end else begin
            hcnt <= hcnt + 1'b1;
        end
    end
endmodule

// File: rtl/afs_frame_seq.sv
module afs_frame_seq
    import afs_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  en,
    input  logic  drive_evt,
    input  geom_t geom,
    output fpos_t nxt,
    output logic  sync_act
);
    logic  run;
    fpos_t cur;
    logic  nsync;

    always_comb begin
        nxt = cur;
        if (!run) begin
            nxt = '0;
        end else if (cur.bitn == geom.bits_m1) begin
            nxt.bitn = '0;
            if (cur.slot == geom.slots_m1) begin
                nxt.slot = '0;
                nxt.fcnt = '0;
            end else begin
                nxt.slot = cur.slot + 1'b1;
                nxt.fcnt = cur.fcnt + 1'b1;
            end
        end else begin
            nxt.bitn = cur.bitn + 1'b1;
            nxt.fcnt = cur.fcnt + 1'b1;
        end
    end

    always_comb begin
        if (geom.early)
            nsync = is_last(nxt, geom) || (nxt.fcnt < FPOS_W'(geom.sync_m1));
        else
            nsync = (nxt.fcnt <= FPOS_W'(geom.sync_m1));
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            run      <= 1'b0;
            cur      <= '0;
            sync_act <= 1'b0;
        end else if (drive_evt) begin
            run      <= 1'b1;
            cur      <= nxt;
            sync_act <= nsync;
        end
    end
endmodule

// File: rtl/afs_word_tx.sv
module afs_word_tx
    import afs_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic                 drive_evt,
    input  fpos_t                nxt,
    input  logic [MAX_SLOTS-1:0] mask,
    input  logic                 lsb_first,
    input  logic                 in_valid,
    input  logic [WORD_W-1:0]    in_data,
    output logic                 in_ready,
    output logic                 sd,
    output logic                 underrun
);
    logic [WORD_W-1:0] word;
    logic              slot_start;
    logic              masked;

    assign slot_start = drive_evt && (nxt.bitn == '0);
    assign masked     = mask[nxt.slot];
    assign in_ready   = slot_start && !masked;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            word     <= '0;
            sd       <= 1'b0;
            underrun <= 1'b0;
        end else if (slot_start) begin
            if (masked || !in_valid) begin
                word <= '0;
                sd   <= 1'b0;
                if (!masked) underrun <= 1'b1;
            end else begin
                word <= in_data;
                sd   <= pick_bit(in_data, '0, lsb_first);
            end
        end else if (drive_evt) begin
            sd <= pick_bit(word, nxt.bitn, lsb_first);
        end
    end
endmodule

// File: rtl/audio_frame_tx.sv
module audio_frame_tx
    import afs_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic [DIV_W-1:0]     div_i,
    input  logic                 bclk_inv_i,
    input  logic                 fs_early_i,
    input  logic                 fs_low_i,
    input  logic [BIT_W-1:0]     fs_width_i,
    input  logic [BIT_W-1:0]     slot_bits_i,
    input  logic [SLOT_W-1:0]    slot_num_i,
    input  logic                 lsb_first_i,
    input  logic [MAX_SLOTS-1:0] slot_mask_i,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [WORD_W-1:0]    in_data,
    output logic                 bclk_o,
    output logic                 fsync_o,
    output logic                 sd_o,
    output logic                 underrun_o
);
    logic  bclk_int;
    logic  drive_evt;
    logic  sync_act;
    fpos_t nxt;
    geom_t geom;

    always_comb begin
        geom.early    = fs_early_i;
        geom.sync_m1  = fs_width_i;
        geom.bits_m1  = slot_bits_i;
        geom.slots_m1 = slot_num_i;
    end

    afs_bclk_div u_div (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .div       (div_i),
        .bclk_int  (bclk_int),
        .drive_evt (drive_evt)
    );

    afs_frame_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .drive_evt (drive_evt),
        .geom      (geom),
        .nxt       (nxt),
        .sync_act  (sync_act)
    );

    afs_word_tx u_word (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .drive_evt (drive_evt),
        .nxt       (nxt),
        .mask      (slot_mask_i),
        .lsb_first (lsb_first_i),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_ready  (in_ready),
        .sd        (sd_o),
        .underrun  (underrun_o)
    );

    assign bclk_o  = bclk_int ^ bclk_inv_i;
    assign fsync_o = sync_act ^ fs_low_i;
endmodule

// File: rtl/audio_frame_tx_chk.sv
module audio_frame_tx_chk (
    input logic       clk,
    input logic       rst,
    input logic       en,
    input logic [7:0] div_i,
    input logic       bclk_inv_i,
    input logic       fs_low_i,
    input logic       in_ready,
    input logic       bclk_o,
    input logic       fsync_o,
    input logic       sd_o,
    input logic       underrun_o
);
    // R3: data moves only as the bit clock reaches its drive level
    a_r3_data_on_drive: assert property (@(posedge clk) disable iff (rst)
        (en && $past(en) && sd_o != $past(sd_o))
        |-> (bclk_o == bclk_inv_i && $past(bclk_o) != bclk_inv_i));

    // R3: sync moves on the same edge as data
    a_r3_sync_on_drive: assert property (@(posedge clk) disable iff (rst)
        (en && $past(en) && fsync_o != $past(fsync_o))
        |-> (bclk_o == bclk_inv_i && $past(bclk_o) != bclk_inv_i));

    // R1: with a non-zero divider no level lasts a single clock
    a_r1_half_period: assert property (@(posedge clk) disable iff (rst)
        (en && $past(en) && div_i != 8'd0 && bclk_o != $past(bclk_o))
        |=> (!en || $stable(bclk_o)));

    // R2: pins idle once a disabled cycle has been seen
    a_r2_idle: assert property (@(posedge clk) disable iff (rst)
        !$past(en) |-> (bclk_o == !bclk_inv_i && fsync_o == fs_low_i
                        && !sd_o && !underrun_o));

    // R10: flag is sticky while enabled
    a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
        ($past(en) && $past(underrun_o)) |-> underrun_o);

    // R11: a word is accepted only in a drive cycle
    a_r11_ready_drive: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> (en && bclk_o != bclk_inv_i));
endmodule

bind audio_frame_tx audio_frame_tx_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .div_i      (div_i),
    .bclk_inv_i (bclk_inv_i),
    .fs_low_i   (fs_low_i),
    .in_ready   (in_ready),
    .bclk_o     (bclk_o),
    .fsync_o    (fsync_o),
    .sd_o       (sd_o),
    .underrun_o (underrun_o)
);

// File: tb/tb_audio_frame_tx.sv
module tb_audio_frame_tx;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic [7:0]  div_i = '0;
    logic        bclk_inv_i = 1'b0, fs_early_i = 1'b0, fs_low_i = 1'b0;
    logic [4:0]  fs_width_i = '0, slot_bits_i = 5'd31;
    logic [3:0]  slot_num_i = 4'd1;
    logic        lsb_first_i = 1'b0;
    logic [15:0] slot_mask_i = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_data = '0;
    logic        bclk_o, fsync_o, sd_o, underrun_o;

    int total = 0;
    int bad = 0;
    int tb_idx = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    audio_frame_tx dut (
        .clk(clk), .rst(rst), .en(en), .div_i(div_i), .bclk_inv_i(bclk_inv_i),
        .fs_early_i(fs_early_i), .fs_low_i(fs_low_i), .fs_width_i(fs_width_i),
        .slot_bits_i(slot_bits_i), .slot_num_i(slot_num_i), .lsb_first_i(lsb_first_i),
        .slot_mask_i(slot_mask_i), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .bclk_o(bclk_o), .fsync_o(fsync_o), .sd_o(sd_o),
        .underrun_o(underrun_o)
    );

    function automatic logic [31:0] wgen(input int i);
        return (32'(i) + 32'd1) * 32'h9E37_79B1 ^ 32'hA5C3_0F1E;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    // watchdog
    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 190000) begin
                bad++;
                total++;
                $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 190000);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    // producer: advances its word after each accepted transfer
    initial begin
        forever begin
            @(negedge clk);
            if (in_valid && in_ready) begin
                @(posedge clk);
                #1;
                tb_idx++;
                in_data = wgen(tb_idx);
            end
        end
    end

    task automatic run_case(input bit binv, input int dv, input bit early,
                            input bit flow, input int sw, input int ss, input int sc,
                            input bit lsb, input logic [15:0] msk, input bit vld,
                            input int nbits);
        int slot, bitn, fcnt, midx, edges, since, sd_err, fs_err, per_err;
        logic [31:0] mword;
        logic prev, cur, exp_sd, exp_fs, last, act, exp_ur;
        longint sd_a, sd_e, fs_a, fs_e, pr_a;
        string tfs, tsd;
        int took;
        step();
        en = 1'b0;
        div_i = 8'(dv); bclk_inv_i = binv; fs_early_i = early; fs_low_i = flow;
        fs_width_i = 5'(sw); slot_bits_i = 5'(ss); slot_num_i = 4'(sc);
        lsb_first_i = lsb; slot_mask_i = msk; in_valid = vld;
        tb_idx = 0; in_data = wgen(0);
        repeat (3) step();
        @(negedge clk);
        check(bclk_o == !binv && fsync_o == flow && sd_o == 1'b0, "R2", "idle pins",
              {bclk_o, fsync_o, sd_o}, {!binv, flow, 1'b0});
        step();
        en = 1'b1;
        slot = 0; bitn = 0; fcnt = 0; midx = 0; edges = 0; since = 0;
        sd_err = 0; fs_err = 0; per_err = 0; mword = '0; exp_ur = 1'b0;
        sd_a = 0; sd_e = 0; fs_a = 0; fs_e = 0; pr_a = 0;
        prev = bclk_o;
        while (edges < nbits) begin
            @(negedge clk);
            since++;
            cur = bclk_o;
            if (cur != prev && cur == !binv) begin
                if (bitn == 0) begin
                    if (msk[slot]) mword = '0;
                    else if (vld) begin mword = wgen(midx); midx++; end
                    else begin mword = '0; exp_ur = 1'b1; end
                end
                exp_sd = msk[slot] ? 1'b0 : (lsb ? mword[bitn] : mword[31 - bitn]);
                last = (slot == sc) && (bitn == ss);
                act = early ? (last || fcnt < sw) : (fcnt <= sw);
                exp_fs = act ^ flow;
                if (sd_o !== exp_sd) begin
                    if (sd_err == 0) begin sd_a = sd_o; sd_e = exp_sd; end
                    sd_err++;
                end
                if (fsync_o !== exp_fs) begin
                    if (fs_err == 0) begin fs_a = fsync_o; fs_e = exp_fs; end
                    fs_err++;
                end
                if (edges > 0 && since != 2 * (dv + 1)) begin
                    if (per_err == 0) pr_a = since;
                    per_err++;
                end
                since = 0;
                if (bitn == ss) begin
                    bitn = 0;
                    if (slot == sc) begin slot = 0; fcnt = 0; end
                    else begin slot++; fcnt++; end
                end else begin
                    bitn++; fcnt++;
                end
                edges++;
            end
            prev = cur;
        end
        took = tb_idx;
        tfs = flow ? "R6" : (early ? "R5" : "R4");
        tsd = !vld ? "R10" : (msk != 0 ? "R9" : (binv ? "R3" : (lsb ? "R8" : "R7")));
        check(fs_err == 0, tfs, "sync level", fs_a, fs_e);
        check(sd_err == 0, tsd, "data bit", sd_a, sd_e);
        check(per_err == 0, "R1", "bit clock period", pr_a, 2 * (dv + 1));
        check(took == midx, "R11", "words accepted", took, midx);
        check(underrun_o == exp_ur, "R10", "underrun flag", underrun_o, exp_ur);
        step();
        en = 1'b0;
        repeat (3) step();
        @(negedge clk);
        check(underrun_o == 1'b0 && sd_o == 1'b0 && bclk_o == !binv, "R2",
              "idle after disable", {underrun_o, sd_o, bclk_o}, {2'b00, !binv});
    endtask

    initial begin
        void'($urandom(32'd7319));
        repeat (4) @(posedge clk);
        #2 rst = 1'b0;
        @(negedge clk);
        check(bclk_o == 1'b1 && sd_o == 1'b0 && fsync_o == 1'b0 && underrun_o == 1'b0,
              "R2", "reset state", {bclk_o, sd_o, fsync_o, underrun_o}, 4'b1000);
        // two-slot early-sync format, divider 6
        run_case(0, 6, 1, 0, 31, 31, 1, 0, 16'h0000, 1, 192);
        // eight-slot one-bit sync
        run_case(0, 1, 0, 0, 0, 31, 7, 0, 16'h0000, 1, 600);
        // 16-bit slots, active-low sync
        run_case(0, 2, 0, 1, 15, 15, 1, 0, 16'h0000, 1, 100);
        // swapped clock edge, LSB first, early short sync
        run_case(1, 0, 1, 0, 2, 23, 3, 1, 16'h0000, 1, 200);
        // LSB first alone
        run_case(0, 1, 0, 0, 3, 11, 2, 1, 16'h0000, 1, 90);
        // masked slots 0 and 2
        run_case(0, 1, 0, 0, 0, 7, 3, 0, 16'h0005, 1, 80);
        // starved input
        run_case(0, 0, 0, 0, 7, 7, 1, 0, 16'h0000, 0, 40);
        // single slot, early sync of one bit
        run_case(0, 0, 1, 0, 0, 7, 0, 0, 16'h0000, 1, 30);
        for (int k = 0; k < 6; k++) begin
            int dv, ss, sc, fl, sw;
            logic [15:0] msk;
            dv = int'($urandom % 4);
            ss = 3 + int'($urandom % 29);
            sc = int'($urandom % 4);
            fl = (sc + 1) * (ss + 1);
            sw = int'($urandom % 32'(ss + 1));
            msk = 16'($urandom) & 16'((1 << (sc + 1)) - 1);
            if (k < 3) msk = '0;
            run_case(1'($urandom), dv, 1'($urandom), 1'($urandom), sw, ss, sc,
                     1'($urandom), msk, 1'b1, 2 * fl + 3);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule